// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which page frame to evict when a page fault occurs. It keeps one referenced flag per frame and a hand pointer that walks the frames as a ring. Software-visible memory activity reports references through a strobe with a frame index, and each strobe sets that frame's flag. A periodic tick wipes every flag. Frames are never reordered. Only the hand moves.

When a fault request arrives, the block looks at one frame per clock, starting at the hand. A frame whose flag is set is given another chance: its flag is cleared and the hand steps on. The first frame found with a clear flag is the victim. Its index is presented with a one-cycle done pulse, and the hand moves to the frame after it. If every flag was set, the scan goes once around the ring, clearing flags as it passes, and ends on the frame where it started. This is plain oldest-first order.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset the hand is at frame 0, busy_o and done_o are low, and every referenced flag is clear.
- R2: A reference strobe (ref_valid_i high with frame index ref_idx_i) sets that frame's referenced flag from the next cycle on.
- R3: A clear tick while idle clears every referenced flag. A reference strobe in the same cycle still sets its frame's flag.
- R4: A fault request while idle raises busy_o in the next cycle. The scan then examines one frame per cycle, beginning at the hand.
- R5: A frame examined with its flag set has the flag cleared, and the hand advances by one, wrapping from the last frame to frame 0.
- R6: A frame examined with its flag clear is the victim. In the next cycle done_o is high for one cycle, victim_idx_o holds that frame, busy_o is low, and hand_o is the frame after the victim.
- R7: If every flag is set at the start of a fault, the victim is the frame where the hand started, after exactly N+1 busy cycles.
- R8: Reference strobes during a scan are applied. A frame still ahead of the hand that is referenced this way is skipped.
- R9: A clear tick during a scan has no effect on the scan. It is held and applied in the cycle after the scan ends.
- R10: A fault request while busy_o is high is ignored. It does not extend or restart the scan.
- R11: The hand does not move in any cycle in which busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_valid_i | input | 1 | Reference strobe |
| ref_idx_i | input | IDX_W | Frame index being referenced |
| clear_tick_i | input | 1 | Periodic request to clear all referenced flags |
| fault_req_i | input | 1 | Request to select a victim |
| busy_o | output | 1 | High while a scan is in progress |
| done_o | output | 1 | One-cycle pulse when a victim is chosen |
| victim_idx_o | output | IDX_W | Chosen frame, valid with done_o |
| hand_o | output | IDX_W | Current hand position |

## Verification
The assertions check, on every cycle, the cycle-level rules:
- the hand steps on every busy cycle and holds when idle;
- a reference sets its flag;
- an idle tick empties the flags;
- a tick seen while busy is held;
- done never overlaps busy, and it reports the frame that was under the hand.

Some behaviour depends on the whole history of flags and hand, and only the bench scenarios can show it:
- which frame is actually chosen;
- the full-ring fallback and its N+1 length;
- skipping a frame that was referenced ahead of the hand mid-scan;
- a deferred tick leaving the current scan unchanged.

The bench covers these by comparing against a behavioural model every cycle, and with scenarios whose victims are worked out by hand.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/ref_bits.sv
module ref_bits #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_valid_i,
  input  logic [IDX_W-1:0]      ref_idx_i,
  input  logic                  clr_all_i,
  input  logic                  scan_clr_i,
  input  logic [IDX_W-1:0]      scan_idx_i,
  output logic [NUM_FRAMES-1:0] r_o
);
  logic [NUM_FRAMES-1:0] r_q;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_bit
    logic set_hit, scan_hit;
    assign set_hit  = ref_valid_i && (ref_idx_i == IDX_W'(g));
    assign scan_hit = scan_clr_i && (scan_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        r_q[g] <= 1'b0;
      else if (set_hit)   r_q[g] <= 1'b1;  // reference wins over any clear
      else if (scan_hit)  r_q[g] <= 1'b0;
      else if (clr_all_i) r_q[g] <= 1'b0;
    end
  end

  assign r_o = r_q;

  p_ref_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && int'(ref_idx_i) < NUM_FRAMES) |=> r_q[$past(ref_idx_i)]);

  p_clear_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && !ref_valid_i) |=> (r_q == '0));
endmodule

// File: rtl/hand_ptr.sv
module hand_ptr #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] hand_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  logic [IDX_W-1:0] hand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hand_q <= '0;
    else if (adv_i) hand_q <= (hand_q == LAST) ? '0 : hand_q + 1'b1;
  end

  assign hand_o = hand_q;

  p_hand_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(hand_q) < NUM_FRAMES);
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import clock_sel_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_req_i,
  input  logic             clear_tick_i,
  input  logic             cur_ref_i,
  input  logic [IDX_W-1:0] hand_i,
  output logic             busy_o,
  output logic             adv_o,
  output logic             scan_clr_o,
  output logic             clr_all_o,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_o
);
  scan_st_e         state_q, state_d;
  logic             tick_pend_q;
  logic             done_q;
  logic [IDX_W-1:0] victim_q;
  logic             scanning, hit_victim;

  assign scanning   = (state_q == ST_SCAN);
  assign hit_victim = scanning && !cur_ref_i;
  assign busy_o     = scanning;
  assign adv_o      = scanning;
  assign scan_clr_o = scanning && cur_ref_i;
  assign clr_all_o  = !scanning && (clear_tick_i || tick_pend_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (fault_req_i) state_d = ST_SCAN;
      ST_SCAN: if (!cur_ref_i)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tick_pend_q <= 1'b0;
      done_q      <= 1'b0;
      victim_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= hit_victim;
      if (hit_victim) victim_q <= hand_i;
      // ticks seen mid-scan wait for idle
      if (scanning && clear_tick_i) tick_pend_q <= 1'b1;
      else if (clr_all_o)           tick_pend_q <= 1'b0;
    end
  end

  assign done_o   = done_q;
  assign victim_o = victim_q;

  p_tick_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && clear_tick_i) |=> (tick_pend_q || clr_all_o));

  p_done_not_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_victim_was_hand_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (victim_o == $past(hand_i) && $past(busy_o)));

  p_fault_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cur_ref_i && fault_req_i) |=> busy_o);
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NUM_FRAMES = 8,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_valid_i,
  input  logic [IDX_W-1:0] ref_idx_i,
  input  logic             clear_tick_i,
  input  logic             fault_req_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_idx_o,
  output logic [IDX_W-1:0] hand_o
);
  logic [NUM_FRAMES-1:0] r_vec;
  logic [IDX_W-1:0]      hand;
  logic                  adv, scan_clr, clr_all, cur_ref;

  assign cur_ref = r_vec[hand];

  ref_bits #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_valid_i(ref_valid_i),
    .ref_idx_i  (ref_idx_i),
    .clr_all_i  (clr_all),
    .scan_clr_i (scan_clr),
    .scan_idx_i (hand),
    .r_o        (r_vec)
  );

  hand_ptr #(.NUM_FRAMES(NUM_FRAMES)) u_hand (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .hand_o(hand)
  );

  scan_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_req_i (fault_req_i),
    .clear_tick_i(clear_tick_i),
    .cur_ref_i   (cur_ref),
    .hand_i      (hand),
    .busy_o      (busy_o),
    .adv_o       (adv),
    .scan_clr_o  (scan_clr),
    .clr_all_o   (clr_all),
    .done_o      (done_o),
    .victim_o    (victim_idx_o)
  );

  assign hand_o = hand;

  p_busy_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && fault_req_i) |=> busy_o);

  p_hand_steps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (hand_o != $past(hand_o)));

  p_hand_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(hand_o));
endmodule

// File: tb/sim_clock_victim_sel.sv
`timescale 1ns/1ps
module sim_clock_victim_sel;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_valid = 1'b0;
  logic [W-1:0] ref_idx = '0;
  logic         clear_tick = 1'b0;
  logic         fault_req = 1'b0;
  logic         busy, done;
  logic [W-1:0] victim, hand;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  clock_victim_sel #(.NUM_FRAMES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_valid_i(ref_valid), .ref_idx_i(ref_idx),
    .clear_tick_i(clear_tick), .fault_req_i(fault_req),
    .busy_o(busy), .done_o(done), .victim_idx_o(victim), .hand_o(hand)
  );

  // behavioural reference model
  bit m_r[N];
  int m_hand = 0;
  bit m_scan = 0, m_pend = 0, m_done = 0;
  int m_vic = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_r[i]) m_r[i] = 0;
      m_hand = 0; m_scan = 0; m_pend = 0; m_done = 0; m_vic = 0;
    end else begin
      bit nr[N];
      bit was_scan;
      nr = m_r;
      was_scan = m_scan;
      m_done = 0;
      if (was_scan) begin
        if (m_r[m_hand]) nr[m_hand] = 0;
        else begin m_done = 1; m_vic = m_hand; m_scan = 0; end
        m_hand = (m_hand + 1) % N;
        if (clear_tick) m_pend = 1;
      end else begin
        if (clear_tick || m_pend) begin
          foreach (nr[i]) nr[i] = 0;
          m_pend = 0;
        end
        if (fault_req) m_scan = 1;
      end
      if (ref_valid) nr[ref_idx] = 1;
      m_r = nr;
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_scan, "R4/R6 busy vs model", busy, m_scan);
      chk(done == m_done, "R6 done vs model", done, m_done);
      chk(int'(hand) == m_hand, "R5/R11 hand vs model", hand, m_hand);
      if (m_done) chk(int'(victim) == m_vic, "R6 victim vs model", victim, m_vic);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_ref(input int idx);
    @(negedge clk);
    ref_valid = 1'b1; ref_idx = W'(idx);
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  // mid_op: 0 none, 1 tick, 2 reference of mid_idx, 3 extra fault; applied in first busy cycle
  task automatic do_fault(input int exp_vic, input int exp_len, input int mid_op,
                          input int mid_idx, input string tag);
    int n;
    @(negedge clk);
    fault_req = 1'b1;
    @(negedge clk);
    fault_req = 1'b0;
    chk(busy == 1'b1, {tag, " R4 busy after request"}, busy, 1);
    if (mid_op == 1) clear_tick = 1'b1;
    if (mid_op == 2) begin ref_valid = 1'b1; ref_idx = W'(mid_idx); end
    if (mid_op == 3) fault_req = 1'b1;
    n = 0;
    while (busy && n < 4 * N) begin
      n++;
      @(negedge clk);
      clear_tick = 1'b0; ref_valid = 1'b0; fault_req = 1'b0;
    end
    chk(done == 1'b1, {tag, " R6 done pulse"}, done, 1);
    chk(int'(victim) == exp_vic, {tag, " R6 victim"}, victim, exp_vic);
    chk(int'(hand) == (exp_vic + 1) % N, {tag, " R6 hand after victim"}, hand, (exp_vic + 1) % N);
    if (exp_len > 0) chk(n == exp_len, {tag, " scan length"}, n, exp_len);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R6 done single cycle"}, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(hand == '0, "R1 reset hand", hand, 0);
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: all flags clear -> first frame chosen in one cycle
    do_fault(0, 1, 0, 0, "R1");
    // R2/R5: referenced frames are skipped
    do_ref(1); do_ref(2); do_ref(3);
    do_fault(4, 4, 0, 0, "R2_R5");
    // R7: all referenced -> start frame after N+1 cycles
    for (int i = 0; i < N; i++) do_ref(i);
    do_fault(5, N + 1, 0, 0, "R7");
    // R3: idle tick clears, same-cycle reference survives
    do_ref(6); do_ref(7);
    @(negedge clk); clear_tick = 1'b1;
    @(negedge clk); clear_tick = 1'b0;
    do_fault(6, 1, 0, 0, "R3 tick");
    @(negedge clk); clear_tick = 1'b1; ref_valid = 1'b1; ref_idx = 3'd7;
    @(negedge clk); clear_tick = 1'b0; ref_valid = 1'b0;
    do_fault(0, 2, 0, 0, "R3 ref wins");
    // R9: tick mid-scan held; victim unaffected
    do_ref(1); do_ref(2); do_ref(3);
    do_fault(4, 4, 1, 0, "R9");
    // R8: reference ahead of the hand during scan
    do_ref(5);
    do_fault(7, 3, 2, 6, "R8");
    // R10/R11: extra fault while busy ignored, hand still while idle
    do_ref(0); do_ref(1);
    do_fault(2, 3, 3, 0, "R10");
    repeat (3) @(negedge clk);
    chk(!busy, "R10 no restart", busy, 0);
    chk(int'(hand) == 3, "R11 hand idle", hand, 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule